// File: doc/BRIEF.md
# Tri-Mode L1 Cache Controller

This block sits between a core's load/store port and a simple word-wide memory port. One data array holds the data in all three of its runtime modes. In cache mode it is a direct-mapped, write-through cache with 8-word lines. Load misses are refilled one word per beat. Stores are queued in a small store buffer and drained to memory. In scratchpad mode the same array is plain local storage: every access completes at once and the memory port stays silent. In self-test mode the lowest lines of the array return a fixed built-in program, so a core can run straight out of reset without external memory. The words above that region work as scratchpad.

The controller comes out of reset in self-test mode. Software selects another mode by writing a 2-bit code. The new mode takes effect only once the memory port has no work left, and every mode change drops all cached tags. A core whose load misses keeps its request asserted and is answered once the line fill completes. A separate debug port reads and writes the raw array at any time, independent of the core port.

Top module: `l1tm_ctrl`

## Requirements
- R1: After reset the mode output reads 2'b10 (self-test) and the memory port issues no request.
- R2: In self-test mode a load whose word index (address bits [11:2]) is below 16 returns 32'hC0DE0000 OR the index. The exception is index 15, which returns the toggle opcode 32'h70661E0F. Stores into that region are accepted and have no effect.
- R3: In self-test mode, words at index 16 and above act as scratchpad storage, and no memory request is made.
- R4: Mode codes are 2'b00 cache, 2'b01 scratchpad, 2'b10 self-test. A write of 2'b11 is ignored. A mode write takes effect only after the memory port is idle, and applying a new mode invalidates every cached line.
- R5: In scratchpad mode every load and store completes in the cycle it is presented, and the memory port never raises a request.
- R6: In cache mode a load miss holds the core not-ready and reads the 8 words of the line from memory in ascending address order, starting at the line base. Once the fill completes, the held load and later loads to that line hit with the memory data.
- R7: A line's tag and valid bit are written only on the final fill beat, so a load to that line is not answered before the eighth word arrives.
- R8: In cache mode each accepted store is written through to memory with the same address, data and byte enables. A store that hits also updates the array.
- R9: When the 4-entry store buffer is full, a cache-mode store is held not-ready until an entry drains. Buffered stores reach memory in issue order.
- R10: The debug port reads and writes array words by word index. If a debug write and a core store target the same word in one cycle, the debug data is kept.
- R11: Byte enables bit b selects data bits [8b+7:8b]. Only enabled bytes of the array word change on a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 2 | Requested mode code |
| mode_o | output | 2 | Mode currently in force |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | 16 | Core byte address |
| core_wdata | input | 32 | Store data |
| core_be | input | 4 | Store byte enables |
| core_ready | output | 1 | Access completes this cycle |
| core_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ack | input | 1 | Memory accepts request; read data valid |
| mem_rdata | input | 32 | Memory read data |
| dbg_en | input | 1 | Debug access enable |
| dbg_we | input | 1 | Debug write |
| dbg_addr | input | 10 | Debug word index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |

## Verification
A debug write and a core store can land on the same array word in one clock edge. The bench provokes this in scratchpad mode, where a store completes at once. It drives both requests to word 200 on the same falling edge and then reads the word back through the debug port. Only the debug value may survive. A mode write that arrives while the stalled memory model still holds a buffered store is a second overlap. There the bench checks that the old mode persists until the store drains, and that the new mode then drops the previously filled line.

// File: rtl/l1tm_pkg.sv
package l1tm_pkg;

  typedef enum logic [1:0] {
    MODE_CACHE = 2'b00,
    MODE_SPAD  = 2'b01,
    MODE_BIST  = 2'b10
  } l1_mode_e;

  localparam logic [31:0] TOGGLE_OP = 32'h7066_1E0F;
  localparam logic [31:0] PROG_TAG  = 32'hC0DE_0000;

  // Built-in self-test program: the last word toggles the liveness pin.
  function automatic logic [31:0] prog_word(input logic [31:0] idx,
                                            input logic [31:0] count);
    if (idx == count - 32'd1) prog_word = TOGGLE_OP;
    else                      prog_word = PROG_TAG | idx;
  endfunction

endpackage

// File: rtl/l1tm_tag_store.sv
module l1tm_tag_store #(
  parameter int LINES  = 128,
  parameter int TAG_W  = 4,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              clr_en,
  input  logic [LIDX_W-1:0] clr_line,
  input  logic              set_en,
  input  logic [LIDX_W-1:0] set_line,
  input  logic [TAG_W-1:0]  set_tag,
  input  logic [LIDX_W-1:0] rd_line,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clear_all) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_line] <= 1'b0;
      if (set_en) valid_q[set_line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_line] <= set_tag;
  end

  assign rd_valid = valid_q[rd_line];
  assign rd_tag   = tag_q[rd_line];
endmodule

// File: rtl/l1tm_store_buf.sv
module l1tm_store_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 52,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_data;
  end

  assign head  = slot_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/l1tm_fill_seq.sv
module l1tm_fill_seq #(
  parameter int LINE_WORDS = 8,
  parameter int LIDX_W     = 7,
  parameter int TAG_W      = 4,
  localparam int WOFF_W    = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LIDX_W-1:0] start_line,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic              ack,
  output logic              busy,
  output logic [LIDX_W-1:0] line,
  output logic [TAG_W-1:0]  tag,
  output logic [WOFF_W-1:0] beat,
  output logic              beat_we,
  output logic              done
);
  localparam logic [WOFF_W-1:0] LAST = WOFF_W'(LINE_WORDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      line <= '0;
      tag  <= '0;
      beat <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      line <= start_line;
      tag  <= start_tag;
      beat <= '0;
    end else if (busy && ack) begin
      beat <= beat + WOFF_W'(1);
      if (beat == LAST) busy <= 1'b0;
    end
  end

  assign beat_we = busy && ack;
  assign done    = beat_we && (beat == LAST);
endmodule

// File: rtl/l1tm_ctrl.sv
module l1tm_ctrl
  import l1tm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 8,
  parameter int ARRAY_WORDS = 1024,
  parameter int SB_DEPTH    = 4,
  parameter int PROG_LINES  = 2,
  localparam int BE_W       = DATA_W / 8,
  localparam int BOFF       = $clog2(BE_W),
  localparam int IDX_W      = $clog2(ARRAY_WORDS),
  localparam int WOFF_W     = $clog2(LINE_WORDS),
  localparam int LINES      = ARRAY_WORDS / LINE_WORDS,
  localparam int LIDX_W     = $clog2(LINES),
  localparam int TAG_W      = ADDR_W - BOFF - IDX_W,
  localparam int PROG_WORDS = PROG_LINES * LINE_WORDS,
  localparam int SB_W       = ADDR_W + DATA_W + BE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  output logic [1:0]        mode_o,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic [BE_W-1:0]   core_be,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dbg_en,
  input  logic              dbg_we,
  input  logic [IDX_W-1:0]  dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata
);
  localparam logic [IDX_W:0] PROG_LIM = (IDX_W + 1)'(PROG_WORDS);

  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [BE_W-1:0]   be);
    merge_bytes = old_w;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) merge_bytes[b*8 +: 8] = new_w[b*8 +: 8];
  endfunction

  // ---------------- mode register ----------------
  l1_mode_e mode_r, pend_mode;
  logic     pend_valid, cfg_ok, mode_apply, mem_idle;

  assign cfg_ok     = cfg_we && (cfg_mode != 2'b11);
  assign mode_apply = pend_valid && mem_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r     <= MODE_BIST;
      pend_mode  <= MODE_BIST;
      pend_valid <= 1'b0;
    end else begin
      if (mode_apply) begin
        mode_r     <= pend_mode;
        pend_valid <= 1'b0;
      end
      if (cfg_ok) begin
        pend_valid <= 1'b1;
        pend_mode  <= l1_mode_e'(cfg_mode);
      end
    end
  end
  assign mode_o = mode_r;

  // ---------------- core address decode ----------------
  logic [IDX_W-1:0]  a_idx;
  logic [LIDX_W-1:0] a_line;
  logic [TAG_W-1:0]  a_tag;
  logic              is_cache, is_bist, in_prog;

  assign a_idx    = core_addr[BOFF +: IDX_W];
  assign a_line   = a_idx[IDX_W-1 -: LIDX_W];
  assign a_tag    = core_addr[ADDR_W-1 -: TAG_W];
  assign is_cache = (mode_r == MODE_CACHE);
  assign is_bist  = (mode_r == MODE_BIST);
  assign in_prog  = is_bist && ({1'b0, a_idx} < PROG_LIM);

  // ---------------- tag store and fill sequencer ----------------
  logic              line_valid, hit, fill_start;
  logic [TAG_W-1:0]  line_tag;
  logic              fill_busy, fill_beat_we, fill_done, fill_ack;
  logic [LIDX_W-1:0] fill_line;
  logic [TAG_W-1:0]  fill_tag;
  logic [WOFF_W-1:0] fill_beat;
  logic              tag_set;
  logic              sb_empty, sb_full, sb_push, sb_pop;
  logic [SB_W-1:0]   sb_head;

  assign hit     = line_valid && (line_tag == a_tag);
  assign tag_set = fill_done;

  l1tm_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (mode_apply),
    .clr_en    (fill_start),
    .clr_line  (a_line),
    .set_en    (tag_set),
    .set_line  (fill_line),
    .set_tag   (fill_tag),
    .rd_line   (a_line),
    .rd_valid  (line_valid),
    .rd_tag    (line_tag)
  );

  assign fill_start = core_req && !core_we && is_cache && !hit &&
                      !fill_busy && sb_empty && !pend_valid;
  assign fill_ack   = mem_ack && sb_empty;

  l1tm_fill_seq #(.LINE_WORDS(LINE_WORDS), .LIDX_W(LIDX_W), .TAG_W(TAG_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fill_start),
    .start_line (a_line),
    .start_tag  (a_tag),
    .ack        (fill_ack),
    .busy       (fill_busy),
    .line       (fill_line),
    .tag        (fill_tag),
    .beat       (fill_beat),
    .beat_we    (fill_beat_we),
    .done       (fill_done)
  );

  // ---------------- core handshake ----------------
  logic accept, store_acc, arr_store_en;

  always_comb begin
    if (!core_req || pend_valid) core_ready = 1'b0;
    else if (is_cache)           core_ready = core_we ? (!sb_full && !fill_busy) : hit;
    else                         core_ready = 1'b1;
  end

  assign accept       = core_req && core_ready;
  assign store_acc    = accept && core_we;
  assign arr_store_en = store_acc && (is_cache ? hit : !in_prog);
  assign sb_push      = store_acc && is_cache;

  // ---------------- data array ----------------
  logic [DATA_W-1:0] arr_q [ARRAY_WORDS];

  always_ff @(posedge clk) begin
    if (fill_beat_we) arr_q[{fill_line, fill_beat}] <= mem_rdata;
    if (arr_store_en) arr_q[a_idx] <= merge_bytes(arr_q[a_idx], core_wdata, core_be);
    if (dbg_en && dbg_we) arr_q[dbg_addr] <= dbg_wdata;   // debug wins a collision
  end

  assign core_rdata = in_prog ? DATA_W'(prog_word(32'(a_idx), 32'(PROG_WORDS)))
                              : arr_q[a_idx];
  assign dbg_rdata  = arr_q[dbg_addr];

  // ---------------- store buffer and memory port ----------------
  l1tm_store_buf #(.DEPTH(SB_DEPTH), .W(SB_W)) u_sbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (sb_push),
    .push_data ({core_addr, core_wdata, core_be}),
    .pop       (sb_pop),
    .head      (sb_head),
    .empty     (sb_empty),
    .full      (sb_full)
  );

  assign sb_pop    = !sb_empty && mem_ack;
  assign mem_idle  = sb_empty && !fill_busy;
  assign mem_req   = !sb_empty || fill_busy;
  assign mem_we    = !sb_empty;
  assign mem_addr  = !sb_empty ? sb_head[SB_W-1 -: ADDR_W]
                               : {fill_tag, fill_line, fill_beat, {BOFF{1'b0}}};
  assign mem_wdata = sb_head[BE_W +: DATA_W];
  assign mem_be    = sb_head[BE_W-1:0];
endmodule

// File: rtl/l1tm_ctrl_chk.sv
module l1tm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       mem_req,
  input logic       mem_we,
  input logic       mem_ack,
  input logic       core_req,
  input logic       core_we,
  input logic       core_ready,
  input logic       sb_full,
  input logic       fill_busy,
  input logic       tag_set
);
  // R5
  spad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) |-> !mem_req);

  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  // R4
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> !$past(mem_req));

  // R7
  tag_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_set |-> (mem_ack && !mem_we && fill_busy));

  // R9
  sb_backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_full && core_req && core_we && mode_o == 2'b00) |-> !core_ready);

  // R8
  fill_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !mem_we);
endmodule

bind l1tm_ctrl l1tm_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_o     (mode_o),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .core_req   (core_req),
  .core_we    (core_we),
  .core_ready (core_ready),
  .sb_full    (sb_full),
  .fill_busy  (fill_busy),
  .tag_set    (tag_set)
);

// File: tb/l1tm_ctrl_test.sv
module l1tm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [1:0]  mode_o;
  logic        core_req = 1'b0, core_we = 1'b0;
  logic [15:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic [3:0]  core_be = '0;
  logic        core_ready;
  logic [31:0] core_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dbg_en = 1'b0, dbg_we = 1'b0;
  logic [9:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic        mem_stall = 1'b0;
  logic [15:0] rlog [16];
  logic [15:0] wlog [16];
  logic [31:0] last_wd;
  logic [3:0]  last_be;

  always #4 clk = ~clk;

  l1tm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode_o(mode_o),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_be(core_be), .core_ready(core_ready),
    .core_rdata(core_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dbg_en(dbg_en), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] pat(input logic [15:0] a);
    pat = {a ^ 16'hA5A5, a};
  endfunction

  // memory model: one-cycle acknowledge pulse, two cycles per transfer
  always @(negedge clk) begin
    if (!rst_n || mem_ack) mem_ack = 1'b0;
    else if (mem_req && !mem_stall) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        wlog[wr_cnt % 16] = mem_addr;
        last_wd = mem_wdata;
        last_be = mem_be;
        wr_cnt++;
      end else begin
        rlog[rd_cnt % 16] = mem_addr;
        mem_rdata = pat(mem_addr);
        rd_cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd, output int waited);
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd; core_be = be;
    waited = 0;
    #1;
    while (!core_ready && waited < 300) begin
      @(negedge clk); #1; waited++;
    end
    rd = core_rdata;
    @(posedge clk); #1;
    core_req = 1'b0; core_we = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic dbg_read(input logic [9:0] i, output logic [31:0] v);
    @(negedge clk); dbg_addr = i; #1; v = dbg_rdata;
  endtask

  task automatic t_reset;
    check("R1 mode after reset", 32'(mode_o), 32'h2);
    check("R1 no memory request", 32'(mem_req), 32'h0);
  endtask

  task automatic t_bist;
    logic [31:0] rd; int w; int r0;
    r0 = rd_cnt + wr_cnt;
    access(1'b0, 16'h0000, '0, '0, rd, w);
    check("R2 program word 0", rd, 32'hC0DE0000);
    access(1'b0, 16'h003C, '0, '0, rd, w);
    check("R2 toggle word", rd, 32'h70661E0F);
    check("R2 no wait", 32'(w), 32'h0);
    access(1'b1, 16'h000C, 32'hFFFFFFFF, 4'hF, rd, w);
    access(1'b0, 16'h000C, '0, '0, rd, w);
    check("R2 store to program ignored", rd, 32'hC0DE0003);
    access(1'b1, 16'h0050, 32'h12345678, 4'hF, rd, w);
    access(1'b0, 16'h0050, '0, '0, rd, w);
    check("R3 scratch above program", rd, 32'h12345678);
    check("R3 no memory traffic", 32'(rd_cnt + wr_cnt - r0), 32'h0);
  endtask

  task automatic t_bad_code;
    set_mode(2'b11);
    check("R4 code 11 ignored", 32'(mode_o), 32'h2);
  endtask

  task automatic t_spad;
    logic [31:0] rd, v; int w; int r0;
    set_mode(2'b01);
    check("R4 scratchpad code", 32'(mode_o), 32'h1);
    r0 = rd_cnt + wr_cnt;
    access(1'b1, 16'h0060, 32'h12345678, 4'hF, rd, w);
    check("R5 store immediate", 32'(w), 32'h0);
    access(1'b1, 16'h0060, 32'h000000AB, 4'b0001, rd, w);
    access(1'b0, 16'h0060, '0, '0, rd, w);
    check("R11 byte enable merge", rd, 32'h123456AB);
    check("R5 load immediate", 32'(w), 32'h0);
    // debug write then core read
    @(negedge clk); dbg_en = 1'b1; dbg_we = 1'b1; dbg_addr = 10'd100; dbg_wdata = 32'hCAFEF00D;
    @(negedge clk); dbg_en = 1'b0; dbg_we = 1'b0;
    access(1'b0, 16'h0190, '0, '0, rd, w);
    check("R10 debug write seen by core", rd, 32'hCAFEF00D);
    dbg_read(10'd24, v);
    check("R10 debug read", v, 32'h123456AB);
    // collision: core store and debug write to word 200 on one edge
    @(negedge clk);
    core_req = 1'b1; core_we = 1'b1; core_addr = 16'h0320; core_wdata = 32'h11111111; core_be = 4'hF;
    dbg_en = 1'b1; dbg_we = 1'b1; dbg_addr = 10'd200; dbg_wdata = 32'h22222222;
    @(posedge clk); #1;
    core_req = 1'b0; core_we = 1'b0; dbg_en = 1'b0; dbg_we = 1'b0;
    dbg_read(10'd200, v);
    check("R10 debug wins collision", v, 32'h22222222);
    check("R5 no memory traffic", 32'(rd_cnt + wr_cnt - r0), 32'h0);
  endtask

  task automatic t_fill;
    logic [31:0] rd, v; int w; int r0; logic ok;
    set_mode(2'b00);
    check("R4 cache code", 32'(mode_o), 32'h0);
    r0 = rd_cnt;
    access(1'b0, 16'h1100, '0, '0, rd, w);
    check("R6 miss returns memory data", rd, pat(16'h1100));
    check("R7 not answered before last beat", 32'(w >= 16), 32'h1);
    check("R6 eight reads", 32'(rd_cnt - r0), 32'h8);
    ok = 1'b1;
    for (int k = 0; k < 8; k++)
      if (rlog[(r0 + k) % 16] !== 16'h1100 + 16'(4 * k)) ok = 1'b0;
    check("R6 ascending fill order", 32'(ok), 32'h1);
    access(1'b0, 16'h1108, '0, '0, rd, w);
    check("R6 hit data", rd, pat(16'h1108));
    check("R6 hit no wait", 32'(w), 32'h0);
    dbg_read(10'h042, v);
    check("R10 debug sees fill data", v, pat(16'h1108));
  endtask

  task automatic t_store;
    logic [31:0] rd; int w; int w0;
    w0 = wr_cnt;
    access(1'b1, 16'h1104, 32'h0000BEEF, 4'b0011, rd, w);
    repeat (6) @(negedge clk);
    check("R8 write-through count", 32'(wr_cnt - w0), 32'h1);
    check("R8 write address", 32'(wlog[w0 % 16]), 32'h1104);
    check("R8 write data", last_wd, 32'h0000BEEF);
    check("R8 write enables", 32'(last_be), 32'h3);
    access(1'b0, 16'h1104, '0, '0, rd, w);
    check("R11 hit store merged", rd, {pat(16'h1104)[31:16], 16'hBEEF});
  endtask

  task automatic t_full;
    logic [31:0] rd; int w; int w0; logic ok;
    w0 = wr_cnt;
    mem_stall = 1'b1;
    for (int k = 0; k < 4; k++)
      access(1'b1, 16'h2000 + 16'(4 * k), 32'(k), 4'hF, rd, w);
    @(negedge clk);
    core_req = 1'b1; core_we = 1'b1; core_addr = 16'h2010; core_wdata = 32'h5; core_be = 4'hF;
    #1;
    check("R9 full buffer holds store", 32'(core_ready), 32'h0);
    @(negedge clk); #1;
    check("R9 still held", 32'(core_ready), 32'h0);
    mem_stall = 1'b0;
    w = 0;
    while (!core_ready && w < 100) begin @(negedge clk); #1; w++; end
    @(posedge clk); #1; core_req = 1'b0; core_we = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 all stores drained", 32'(wr_cnt - w0), 32'h5);
    ok = 1'b1;
    for (int k = 0; k < 5; k++)
      if (wlog[(w0 + k) % 16] !== 16'h2000 + 16'(4 * k)) ok = 1'b0;
    check("R9 drain order", 32'(ok), 32'h1);
  endtask

  task automatic t_switch;
    logic [31:0] rd; int w;
    mem_stall = 1'b1;
    access(1'b1, 16'h3000, 32'h77, 4'hF, rd, w);
    set_mode(2'b01);
    check("R4 mode held while memory busy", 32'(mode_o), 32'h0);
    mem_stall = 1'b0;
    repeat (8) @(negedge clk);
    check("R4 mode applied after idle", 32'(mode_o), 32'h1);
    set_mode(2'b00);
    access(1'b0, 16'h1108, '0, '0, rd, w);
    check("R4 mode change invalidates", 32'(w >= 16), 32'h1);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_bist();
    t_bad_code();
    t_spad();
    t_fill();
    t_store();
    t_full();
    t_switch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule